// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Detection

This block compares two pulse trains: the divided reference and the divided feedback from the oscillator loop. Both arrive as single-cycle strobes in the system clock domain. A two-register up/down detector measures which edge came first. From that it drives three outputs:

- a three-state loop-filter pump output;
- a push-pull comparator output;
- an open-drain comparator output for an external pump.

A polarity bit swaps the up and down roles so that the loop can match oscillators whose tuning slope is either positive or negative.

A lock detector counts, in system clock periods, how long only one side of the detector is active in each comparison. One over-long comparison drops the lock flag. A run of consecutive short comparisons raises it.

One status pin carries either the lock flag or a monitor copy of the divided input selected by the polarity bit. A power-save input idles the comparator and holds the flag high. A drive-inhibit input floats the pump. The current-select bit is passed straight through to the analog pump.

Top module: `phase_lock_cmp`

## Requirements
- R1: With `pol_hi`=1, a lone reference lead gives `pump_oe`=1, `pump_hi`=1, `cmp_a_o`=0 and `cmp_b_pull`=1. A lone feedback lead gives `pump_oe`=1, `pump_hi`=0, `cmp_a_o`=1 and `cmp_b_pull`=0. Outputs respond one clock after the leading strobe.
- R2: With `pol_hi`=0, the lone-lead cases swap. A reference lead gives `pump_hi`=0, `cmp_a_o`=1 and `cmp_b_pull`=0. A feedback lead gives `pump_hi`=1, `cmp_a_o`=0 and `cmp_b_pull`=1.
- R3: Strobes arriving in the same cycle give a one-cycle pulse on both `cmp_a_o` and `cmp_b_pull`, and the pump stays floating (`pump_oe`=0). Once both sides are active, the detector clears in the next cycle. When idle, `pump_oe`, `cmp_a_o` and `cmp_b_pull` are 0.
- R4: `drive_ok`=0 forces `pump_oe`=0 and leaves `cmp_a_o` and `cmp_b_pull` unchanged.
- R5: One comparison in which exactly one side stays active for 3 or more cycles (`UNLOCK_MIN`) clears the lock flag.
- R6: The lock flag rises after 3 (`LOCK_RUNS`) consecutive comparisons whose one-sided width is 2 cycles or less (`LOCK_MAX`). A wider comparison restarts the run.
- R7: `mon_sel`=1 puts onto `stat_o` the reference strobe (`pol_hi`=1) or the feedback strobe (`pol_hi`=0), delayed by one clock. `mon_sel`=0 puts the lock flag there.
- R8: `active`=0 floats the pump at once and clears the detector at the next edge. It also forces the lock flag on `stat_o` to 1 and clears the lock state, so the flag reads 0 after wake-up.
- R9: After reset or power-save, feedback strobes are ignored until the first reference strobe arrives.
- R10: `isel_o` follows `cur_sel`.
- R11: In reset, `pump_oe`, `cmp_a_o`, `cmp_b_pull` and `stat_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | Divided reference strobe |
| fb_pulse | input | 1 | Divided feedback strobe |
| pol_hi | input | 1 | Polarity select |
| mon_sel | input | 1 | 1: monitor on stat_o, 0: lock flag |
| cur_sel | input | 1 | Pump current select |
| active | input | 1 | 0 selects power-save |
| drive_ok | input | 1 | 0 floats the pump output |
| pump_oe | output | 1 | Pump drive enable |
| pump_hi | output | 1 | Pump drive level |
| cmp_a_o | output | 1 | Push-pull comparator output |
| cmp_b_pull | output | 1 | Open-drain comparator pull-down enable |
| stat_o | output | 1 | Lock flag or monitor |
| isel_o | output | 1 | Current select to analog pump |

## Verification
The output mapping is driven with reference-first and feedback-first strobe pairs under both polarities and with the pump inhibited. This separates a swapped lead/lag assignment from a missing polarity swap or an inhibit that leaks into the comparator pins.

Coincident strobes distinguish the dead-zone pulse from a detector that never clears. One-sided widths of 1, 2, 3 and 4 cycles pin the lock and unlock thresholds at their boundaries. A bad comparison in the middle of a good run shows whether the run counter restarts.

Feedback strobes sent after wake-up and before a reference strobe show whether arming works.

// File: rtl/plc_pkg.sv
package plc_pkg;
  // Returns {lead, lag} after polarity: lead drives the pump high.
  function automatic logic [1:0] orient(input logic pol, input logic up, input logic dn);
    return pol ? {up, dn} : {dn, up};
  endfunction

  // True when the running one-sided width reaches the unlock limit this cycle.
  function automatic logic unlock_due(input int unsigned width, input logic err,
                                      input int unsigned limit);
    return err && ((width + 1) >= limit);
  endfunction

  // True when a finished comparison counts toward lock.
  function automatic logic run_ok(input int unsigned width, input int unsigned limit);
    return width <= limit;
  endfunction
endpackage

// File: rtl/plc_pfd.sv
module plc_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic up_q,
  output logic dn_q,
  output logic armed_q
);
  logic both;
  logic ref_ok;
  logic fb_ok;
  logic up_d;
  logic dn_d;

  assign both   = up_q & dn_q;
  assign ref_ok = active & ref_pulse;
  assign fb_ok  = active & fb_pulse & (armed_q | ref_pulse);
  assign up_d   = ref_ok | (up_q & ~both);
  assign dn_d   = fb_ok | (dn_q & ~both);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (!active) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      up_q    <= up_d;
      dn_q    <= dn_d;
      armed_q <= armed_q | ref_pulse;
    end
  end
endmodule

// File: rtl/plc_lock.sv
module plc_lock #(
  parameter int unsigned UNLOCK_MIN = 3,
  parameter int unsigned LOCK_MAX   = 2,
  parameter int unsigned LOCK_RUNS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic up,
  input  logic dn,
  output logic locked_q,
  output logic unlock_evt,
  output logic good_evt
);
  import plc_pkg::*;

  localparam int unsigned W_W = $clog2(UNLOCK_MIN + 1) + 1;
  localparam int unsigned G_W = $clog2(LOCK_RUNS + 1);

  logic [W_W-1:0] width_q;
  logic [G_W-1:0] runs_q;
  logic           err;
  logic           done;

  assign err        = up ^ dn;
  assign done       = up & dn;
  assign unlock_evt = unlock_due(32'(width_q), err, UNLOCK_MIN);
  assign good_evt   = done & run_ok(32'(width_q), LOCK_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      runs_q   <= '0;
      locked_q <= 1'b0;
    end else if (!active) begin
      width_q  <= '0;
      runs_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (done)
        width_q <= '0;
      else if (err && (width_q < W_W'(UNLOCK_MIN)))
        width_q <= width_q + 1'b1;

      if (unlock_evt) begin
        locked_q <= 1'b0;
        runs_q   <= '0;
      end else if (done) begin
        if (good_evt) begin
          if (runs_q >= G_W'(LOCK_RUNS - 1))
            locked_q <= 1'b1;
          else
            runs_q <= runs_q + 1'b1;
        end else begin
          runs_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/plc_out.sv
module plc_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  input  logic mon_sel,
  input  logic active,
  input  logic drive_ok,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic up,
  input  logic dn,
  input  logic locked,
  output logic pump_oe,
  output logic pump_hi,
  output logic cmp_a_o,
  output logic cmp_b_pull,
  output logic stat_o
);
  import plc_pkg::*;

  logic [1:0] ll;
  logic       mon_q;

  assign ll         = orient(pol, up, dn);
  assign pump_oe    = active & drive_ok & (ll[1] ^ ll[0]);
  assign pump_hi    = pump_oe & ll[1];
  assign cmp_a_o    = ll[0];
  assign cmp_b_pull = ll[1];
  assign stat_o     = mon_sel ? mon_q : (~active | locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mon_q <= 1'b0;
    else        mon_q <= pol ? ref_pulse : fb_pulse;
  end
endmodule

// File: rtl/phase_lock_cmp.sv
module phase_lock_cmp #(
  parameter int unsigned UNLOCK_MIN = 3,
  parameter int unsigned LOCK_MAX   = 2,
  parameter int unsigned LOCK_RUNS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic pol_hi,
  input  logic mon_sel,
  input  logic cur_sel,
  input  logic active,
  input  logic drive_ok,
  output logic pump_oe,
  output logic pump_hi,
  output logic cmp_a_o,
  output logic cmp_b_pull,
  output logic stat_o,
  output logic isel_o
);
  logic up_q;
  logic dn_q;
  logic armed_q;
  logic locked_q;
  logic unlock_evt;
  logic good_evt;

  plc_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .active(active),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .up_q(up_q), .dn_q(dn_q), .armed_q(armed_q)
  );

  plc_lock #(
    .UNLOCK_MIN(UNLOCK_MIN), .LOCK_MAX(LOCK_MAX), .LOCK_RUNS(LOCK_RUNS)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .active(active), .up(up_q), .dn(dn_q),
    .locked_q(locked_q), .unlock_evt(unlock_evt), .good_evt(good_evt)
  );

  plc_out u_out (
    .clk(clk), .rst_n(rst_n), .pol(pol_hi), .mon_sel(mon_sel),
    .active(active), .drive_ok(drive_ok), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .up(up_q), .dn(dn_q), .locked(locked_q),
    .pump_oe(pump_oe), .pump_hi(pump_hi), .cmp_a_o(cmp_a_o),
    .cmp_b_pull(cmp_b_pull), .stat_o(stat_o)
  );

  assign isel_o = cur_sel;
endmodule

// File: rtl/phase_lock_cmp_chk.sv
module phase_lock_cmp_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_pulse,
  input logic fb_pulse,
  input logic mon_sel,
  input logic active,
  input logic drive_ok,
  input logic pump_oe,
  input logic stat_o,
  input logic up_q,
  input logic dn_q,
  input logic armed_q,
  input logic locked_q,
  input logic unlock_evt,
  input logic good_evt
);
  AST_PUMP_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pump_oe |-> (up_q != dn_q)); // R1
  AST_PFD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !ref_pulse && !fb_pulse) |=> (!up_q && !dn_q)); // R3
  AST_FORCE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_ok |-> !pump_oe); // R4
  AST_UNLOCK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && unlock_evt) |=> !locked_q); // R5
  AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(good_evt)); // R6
  AST_SAVE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pump_oe); // R8
  AST_SAVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !mon_sel) |-> stat_o); // R8
  AST_ARM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !ref_pulse) |=> !dn_q); // R9
endmodule

bind phase_lock_cmp phase_lock_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
  .mon_sel(mon_sel), .active(active), .drive_ok(drive_ok),
  .pump_oe(pump_oe), .stat_o(stat_o), .up_q(up_q), .dn_q(dn_q),
  .armed_q(armed_q), .locked_q(locked_q), .unlock_evt(unlock_evt),
  .good_evt(good_evt)
);

// File: tb/phase_lock_cmp_bench.sv
`timescale 1ns/1ps
module phase_lock_cmp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0, fb_pulse = 1'b0, pol_hi = 1'b1, mon_sel = 1'b0;
  logic cur_sel = 1'b0, active = 1'b1, drive_ok = 1'b1;
  logic pump_oe, pump_hi, cmp_a_o, cmp_b_pull, stat_o, isel_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;

  phase_lock_cmp u_phase_lock_cmp (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .pol_hi(pol_hi), .mon_sel(mon_sel), .cur_sel(cur_sel), .active(active),
    .drive_ok(drive_ok), .pump_oe(pump_oe), .pump_hi(pump_hi),
    .cmp_a_o(cmp_a_o), .cmp_b_pull(cmp_b_pull), .stat_o(stat_o), .isel_o(isel_o)
  );

  // {pol, ref_first, drive_ok, gap[2:0], exp oe, exp hi, exp a, exp b}
  localparam logic [9:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 3'd2, 4'b1101},
    {1'b1, 1'b0, 1'b1, 3'd2, 4'b1010},
    {1'b0, 1'b1, 1'b1, 3'd2, 4'b1010},
    {1'b0, 1'b0, 1'b1, 3'd2, 4'b1101},
    {1'b1, 1'b1, 1'b0, 3'd1, 4'b0001},
    {1'b0, 1'b1, 1'b0, 3'd3, 4'b0010},
    {1'b1, 1'b0, 1'b1, 3'd1, 4'b1010},
    {1'b0, 1'b0, 1'b1, 3'd4, 4'b1101}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference strobe, then feedback strobe gap cycles later (gap >= 1).
  task automatic cmp_run(input int gap);
    ref_pulse = 1'b1; @(negedge clk); ref_pulse = 1'b0;
    repeat (gap - 1) @(negedge clk);
    fb_pulse = 1'b1; @(negedge clk); fb_pulse = 1'b0;
    idle(6);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, 50000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R11 reset state
    chk("R11 pump_oe", pump_oe, 1'b0);
    chk("R11 cmp_a_o", cmp_a_o, 1'b0);
    chk("R11 cmp_b_pull", cmp_b_pull, 1'b0);
    chk("R11 stat_o", stat_o, 1'b0);
    rst_n = 1'b1;
    idle(2);
    // R10 pass-through
    cur_sel = 1'b1; #1 chk("R10 isel high", isel_o, 1'b1);
    cur_sel = 1'b0; #1 chk("R10 isel low", isel_o, 1'b0);
    // R3 coincident strobes (also arms the detector)
    @(negedge clk);
    ref_pulse = 1'b1; fb_pulse = 1'b1; @(negedge clk);
    ref_pulse = 1'b0; fb_pulse = 1'b0;
    chk("R3 both a", cmp_a_o, 1'b1);
    chk("R3 both b", cmp_b_pull, 1'b1);
    chk("R3 both pump float", pump_oe, 1'b0);
    @(negedge clk);
    chk("R3 cleared a", cmp_a_o, 1'b0);
    chk("R3 cleared b", cmp_b_pull, 1'b0);

    // Table of lead/lag cases: R1, R2, R4
    for (int i = 0; i < 8; i++) begin
      logic [9:0] v;
      string tag;
      v = VEC[i];
      tag = !v[7] ? "R4" : (v[9] ? "R1" : "R2");
      pol_hi = v[9]; drive_ok = v[7];
      @(negedge clk);
      if (v[8]) ref_pulse = 1'b1; else fb_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0; fb_pulse = 1'b0;
      chk({tag, " pump_oe"}, pump_oe, v[3]);
      chk({tag, " pump_hi"}, pump_hi, v[2]);
      chk({tag, " cmp_a_o"}, cmp_a_o, v[1]);
      chk({tag, " cmp_b_pull"}, cmp_b_pull, v[0]);
      repeat (int'(v[6:4]) - 1) @(negedge clk);
      if (v[8]) fb_pulse = 1'b1; else ref_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0; fb_pulse = 1'b0;
      idle(6);
      chk("R3 idle pump", pump_oe, 1'b0);
      chk("R3 idle a", cmp_a_o, 1'b0);
      chk("R3 idle b", cmp_b_pull, 1'b0);
    end
    pol_hi = 1'b1; drive_ok = 1'b1;

    // Lock and unlock windows
    cmp_run(4); chk("R5 wide unlocks", stat_o, 1'b0);
    cmp_run(1); cmp_run(2); chk("R6 two good not yet", stat_o, 1'b0);
    cmp_run(1); chk("R6 third good locks", stat_o, 1'b1);
    cmp_run(3); chk("R5 width 3 unlocks", stat_o, 1'b0);
    cmp_run(2); cmp_run(2); cmp_run(4);
    cmp_run(1); cmp_run(1); chk("R6 run restarted", stat_o, 1'b0);
    cmp_run(2); chk("R6 relock", stat_o, 1'b1);

    // R7 monitor select
    mon_sel = 1'b1; pol_hi = 1'b1;
    @(negedge clk); ref_pulse = 1'b1; @(negedge clk); ref_pulse = 1'b0;
    chk("R7 ref shown", stat_o, 1'b1);
    fb_pulse = 1'b1; @(negedge clk); fb_pulse = 1'b0;
    chk("R7 ref gone", stat_o, 1'b0);
    @(negedge clk);
    chk("R7 fb hidden", stat_o, 1'b0);
    idle(4);
    pol_hi = 1'b0;
    @(negedge clk); fb_pulse = 1'b1; @(negedge clk); fb_pulse = 1'b0;
    chk("R7 fb shown", stat_o, 1'b1);
    ref_pulse = 1'b1; @(negedge clk); ref_pulse = 1'b0;
    @(negedge clk);
    chk("R7 ref hidden", stat_o, 1'b0);
    idle(4);
    mon_sel = 1'b0; pol_hi = 1'b1;
    @(negedge clk);
    chk("R7 lock flag shown", stat_o, 1'b1);

    // R8 power save, R9 arming
    ref_pulse = 1'b1; @(negedge clk); ref_pulse = 1'b0;
    chk("R1 pending lead", pump_oe, 1'b1);
    active = 1'b0; @(negedge clk);
    chk("R8 save pump float", pump_oe, 1'b0);
    chk("R8 save detector cleared", cmp_b_pull, 1'b0);
    chk("R8 save flag high", stat_o, 1'b1);
    idle(3);
    active = 1'b1; @(negedge clk);
    chk("R8 wake flag low", stat_o, 1'b0);
    fb_pulse = 1'b1; @(negedge clk); fb_pulse = 1'b0;
    chk("R9 fb ignored a", cmp_a_o, 1'b0);
    chk("R9 fb ignored pump", pump_oe, 1'b0);
    idle(3);
    ref_pulse = 1'b1; @(negedge clk); ref_pulse = 1'b0;
    chk("R9 armed pump", pump_oe, 1'b1);
    chk("R9 armed level", pump_hi, 1'b1);
    fb_pulse = 1'b1; @(negedge clk); fb_pulse = 1'b0;
    idle(4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule